// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block generates the column address for every beat of a read or write burst in a synchronous DRAM controller or device model. A read or write command presents a start column, a burst-length code and an ordering bit, all taken from a mode register image. From the next clock edge onward, the block puts out one column per cycle. It stops when the programmed number of beats has been issued. A full-page burst has no fixed end and keeps running.

There are two beat orderings. Sequential ordering counts upward and wraps inside the aligned block of the burst length. Interleaved ordering XORs the beat number into the low address bits. A full-page burst is legal only in sequential ordering. It steps through the whole 1024-column page, wraps from the top column back to zero, and continues until something ends it.

A terminate input stops a burst on the edge where it is sampled. A new command replaces a running burst on the very next edge, with no idle cycle between them. Any combination the block cannot serve is refused and flagged, and it leaves the current state untouched. The CAS-latency pipeline, bank and row handling, and data storage all sit outside this block.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is asserted (synchronous, active high), and on the first cycle after it, `col_valid`, `col_last` and `cfg_reject` are 0.
- R2: A legal `cmd_start` sampled at an edge makes `col_valid` 1 and `col_out` equal to `start_col` after that edge. `len_code` 0, 1, 2 and 3 select 1, 2, 4 and 8 beats, and 7 selects full page. `order_il` 0 selects sequential ordering and 1 selects interleaved.
- R3: In a sequential burst of N beats, beat k is `start_col` with its low log2(N) bits replaced by the low log2(N) bits of (`start_col` + k). The upper bits stay fixed. Exactly N beats are produced, and then `col_valid` falls.
- R4: In an interleaved burst of N beats, beat k is `start_col` with its low log2(N) bits XORed with k. Exactly N beats are produced.
- R5: A full-page sequential burst puts out (`start_col` + k) mod 1024 on beat k. It wraps from 1023 to 0 and runs until it is terminated or replaced.
- R6: `col_last` is 1 exactly on the final beat of a fixed-length burst. It is never 1 during a full-page burst, and never 1 without `col_valid`.
- R7: `cmd_stop` sampled without `cmd_start` makes `col_valid` 0 after that edge. With no burst running, it has no effect.
- R8: A legal `cmd_start` during a burst restarts at the new start column on the next beat, with no gap. When `cmd_start` and `cmd_stop` are sampled together, the start wins.
- R9: A `cmd_start` with `len_code` 4, 5 or 6, or with `len_code` 7 and `order_il` 1, raises `cfg_reject` for one cycle after the edge. It is otherwise ignored: an idle block stays idle, and a burst in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_start | input | 1 | Read or write command strobe |
| cmd_stop | input | 1 | Burst terminate strobe |
| start_col | input | 10 | Start column of the new burst |
| len_code | input | 3 | Burst length code |
| order_il | input | 1 | 0 sequential, 1 interleaved |
| col_out | output | 10 | Column of the current beat |
| col_valid | output | 1 | A beat is being issued this cycle |
| col_last | output | 1 | Current beat is the final one of a fixed burst |
| cfg_reject | output | 1 | Previous command had an illegal length/ordering pair |

## Verification
The assertions assume that every input is a known value once reset has been released. They also assume that `start_col`, `len_code` and `order_il` matter only in a cycle where `cmd_start` is high. The stimulus changes inputs only on falling clock edges, holds each command strobe for exactly one cycle, and leaves the configuration inputs at 0 whenever no command is present. This keeps each property's premise tied to one sampled edge.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

    localparam int COL_W = 10;
    localparam int LEN_W = 3;

    typedef logic [COL_W-1:0] col_t;
    typedef logic [LEN_W-1:0] len_t;

    typedef enum logic [LEN_W-1:0] {
        BLEN_1    = 3'd0,
        BLEN_2    = 3'd1,
        BLEN_4    = 3'd2,
        BLEN_8    = 3'd3,
        BLEN_PAGE = 3'd7
    } blen_e;

    typedef struct packed {
        col_t base;
        col_t mask;
        logic il;
        logic page;
    } burst_cfg_t;

    function automatic col_t len_mask(len_t code);
        case (code)
            BLEN_1:  len_mask = col_t'(0);
            BLEN_2:  len_mask = col_t'(1);
            BLEN_4:  len_mask = col_t'(3);
            BLEN_8:  len_mask = col_t'(7);
            default: len_mask = '1;
        endcase
    endfunction

    function automatic logic len_legal(len_t code, logic il);
        case (code)
            BLEN_1, BLEN_2, BLEN_4, BLEN_8: len_legal = 1'b1;
            BLEN_PAGE:                      len_legal = !il;
            default:                        len_legal = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
    import sdram_burst_pkg::*;
(
    input  col_t       start_col,
    input  len_t       len_code,
    input  logic       order_il,
    output burst_cfg_t cfg,
    output logic       legal
);
    always_comb begin
        cfg.base = start_col;
        cfg.mask = len_mask(len_code);
        cfg.il   = order_il;
        cfg.page = (len_code == BLEN_PAGE);
        legal    = len_legal(len_code, order_il);
    end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
    import sdram_burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       stop,
    input  burst_cfg_t cfg_in,
    output burst_cfg_t cfg_q,
    output col_t       beat_q,
    output logic       active_q,
    output logic       last
);
    logic at_end;

    always_comb begin
        at_end = !cfg_q.page && (beat_q == cfg_q.mask);
        last   = active_q && at_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            beat_q   <= '0;
            active_q <= 1'b0;
        end else if (load) begin
            cfg_q    <= cfg_in;
            beat_q   <= '0;
            active_q <= 1'b1;
        end else if (stop) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            if (at_end) active_q <= 1'b0;
            else        beat_q   <= beat_q + col_t'(1);
        end
    end

    p_fixed_end_r3: assert property (@(posedge clk) disable iff (rst)
        (last && !load && !stop) |=> !active_q);

    p_stop_halts_r7: assert property (@(posedge clk) disable iff (rst)
        (stop && !load) |=> !active_q);

    p_beat_step_r5: assert property (@(posedge clk) disable iff (rst)
        (active_q && !last && !load && !stop) |=> (active_q && beat_q == $past(beat_q) + col_t'(1)));

    p_page_never_last_r6: assert property (@(posedge clk) disable iff (rst)
        (active_q && cfg_q.page) |-> !last);
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
    import sdram_burst_pkg::*;
(
    input  col_t base,
    input  col_t mask,
    input  logic il,
    input  col_t beat,
    output col_t col
);
    col_t seq_col;
    col_t il_col;

    always_comb begin
        seq_col = (base & ~mask) | ((base + beat) & mask);
        il_col  = base ^ (beat & mask);
        col     = il ? il_col : seq_col;
    end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_burst_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_start,
    input  logic                 cmd_stop,
    input  logic [COL_W-1:0]     start_col,
    input  logic [LEN_W-1:0]     len_code,
    input  logic                 order_il,
    output logic [COL_W-1:0]     col_out,
    output logic                 col_valid,
    output logic                 col_last,
    output logic                 cfg_reject
);
    burst_cfg_t cfg_new;
    burst_cfg_t cfg_q;
    logic       legal;
    logic       load;
    col_t       beat_q;
    logic       active_q;
    logic       last;
    col_t       col_w;

    burst_cfg_decode u_decode (
        .start_col (start_col),
        .len_code  (len_code),
        .order_il  (order_il),
        .cfg       (cfg_new),
        .legal     (legal)
    );

    assign load = cmd_start && legal;

    burst_beat_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .stop     (cmd_stop),
        .cfg_in   (cfg_new),
        .cfg_q    (cfg_q),
        .beat_q   (beat_q),
        .active_q (active_q),
        .last     (last)
    );

    burst_col_map u_map (
        .base (cfg_q.base),
        .mask (cfg_q.mask),
        .il   (cfg_q.il),
        .beat (beat_q),
        .col  (col_w)
    );

    always_ff @(posedge clk) begin
        if (rst) cfg_reject <= 1'b0;
        else     cfg_reject <= cmd_start && !legal;
    end

    assign col_out   = col_w;
    assign col_valid = active_q;
    assign col_last  = last;

    p_load_start_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && legal) |=> (col_valid && col_out == $past(start_col)));

    p_reject_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !legal && !col_valid) |=> (cfg_reject && !col_valid));

    p_last_has_valid_r6: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid);

    p_upper_fixed_r3: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !cmd_start) |=> (!col_valid || ((col_out ^ $past(col_out)) & ~cfg_q.mask) == '0));
endmodule

// File: tb/sdram_burst_seq_bench.sv
`timescale 1ns/1ps
module sdram_burst_seq_bench;
    import sdram_burst_pkg::*;

    typedef struct {
        col_t  col;
        logic  last;
        string tag;
    } beat_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_start = 1'b0;
    logic cmd_stop = 1'b0;
    col_t start_col = '0;
    len_t len_code = '0;
    logic order_il = 1'b0;
    col_t col_out;
    logic col_valid;
    logic col_last;
    logic cfg_reject;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    beat_item_t exp_q[$];

    always #2.5 clk = ~clk;

    sdram_burst_seq u_sdram_burst_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .start_col  (start_col),
        .len_code   (len_code),
        .order_il   (order_il),
        .col_out    (col_out),
        .col_valid  (col_valid),
        .col_last   (col_last),
        .cfg_reject (cfg_reject)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic col_t exp_col(col_t b, int n, bit il, int k);
        col_t m;
        if (n == 0) return col_t'(b + col_t'(k));
        m = col_t'(n - 1);
        if (il) return b ^ (col_t'(k) & m);
        return (b & ~m) | ((b + col_t'(k)) & m);
    endfunction

    function automatic len_t code_of(int n);
        case (n)
            1: return 3'd0;
            2: return 3'd1;
            4: return 3'd2;
            8: return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

    // Driver: called at a falling edge; returns one falling edge later.
    task automatic issue(col_t b, int n, bit il, int nexp, bit with_stop, string tag);
        for (int k = 0; k < nexp; k++) begin
            beat_item_t it;
            it.col  = exp_col(b, n, il, k);
            it.last = (n != 0) && (k == n - 1);
            it.tag  = tag;
            exp_q.push_back(it);
        end
        cmd_start = 1'b1;
        cmd_stop  = with_stop;
        start_col = b;
        len_code  = code_of(n);
        order_il  = il;
        @(negedge clk);
        cmd_start = 1'b0;
        cmd_stop  = 1'b0;
        start_col = '0;
        len_code  = '0;
        order_il  = 1'b0;
    endtask

    task automatic bad_cmd(len_t code, bit il, string tag);
        cmd_start = 1'b1;
        len_code  = code;
        order_il  = il;
        start_col = col_t'(100);
        @(negedge clk);
        cmd_start = 1'b0;
        len_code  = '0;
        order_il  = 1'b0;
        start_col = '0;
        check(cfg_reject == 1'b1, {tag, " reject flag"}, int'(cfg_reject), 1);
    endtask

    task automatic pulse_stop();
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
    endtask

    task automatic drain(int cycles, string tag);
        repeat (cycles) @(negedge clk);
        check(exp_q.size() == 0, {tag, " all beats seen"}, exp_q.size(), 0);
        check(col_valid == 1'b0, {tag, " idle after burst"}, int'(col_valid), 0);
    endtask

    // Monitor: compares each issued beat with the scoreboard head.
    always @(negedge clk) begin
        if (!rst && !done && col_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R8 unexpected beat", int'(col_out), -1);
            end else begin
                beat_item_t it;
                it = exp_q.pop_front();
                check(col_out == it.col, {it.tag, " column"}, int'(col_out), int'(it.col));
                check(col_last == it.last, {it.tag, " last flag R6"}, int'(col_last), int'(it.last));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(col_valid == 1'b0 && col_last == 1'b0 && cfg_reject == 1'b0,
              "R1 outputs in reset", {col_valid, col_last, cfg_reject}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(col_valid == 1'b0 && col_last == 1'b0 && cfg_reject == 1'b0,
              "R1 outputs after reset", {col_valid, col_last, cfg_reject}, 0);

        // R2/R3 sequential fixed lengths
        issue(col_t'(6), 4, 1'b0, 4, 1'b0, "R3 seq4");
        drain(5, "R3 seq4");
        issue(col_t'(13), 8, 1'b0, 8, 1'b0, "R3 seq8");
        drain(9, "R3 seq8");
        issue(col_t'(9), 2, 1'b0, 2, 1'b0, "R2 seq2");
        drain(3, "R2 seq2");
        issue(col_t'(1023), 1, 1'b0, 1, 1'b0, "R2 seq1");
        drain(2, "R2 seq1");

        // R4 interleaved
        issue(col_t'(13), 8, 1'b1, 8, 1'b0, "R4 il8");
        drain(9, "R4 il8");
        issue(col_t'(6), 4, 1'b1, 4, 1'b0, "R4 il4");
        drain(5, "R4 il4");
        issue(col_t'(515), 2, 1'b1, 2, 1'b0, "R4 il2");
        drain(3, "R4 il2");

        // R5 full page with wrap, ended by terminate (R7)
        issue(col_t'(1020), 0, 1'b0, 1030, 1'b0, "R5 page");
        repeat (1029) @(negedge clk);
        pulse_stop();
        drain(2, "R5/R7 page stop");

        // R7 terminate a fixed burst after 3 beats
        issue(col_t'(40), 8, 1'b0, 3, 1'b0, "R7 cut");
        repeat (2) @(negedge clk);
        pulse_stop();
        drain(2, "R7 cut");

        // R7 terminate while idle
        pulse_stop();
        check(col_valid == 1'b0, "R7 stop while idle", int'(col_valid), 0);

        // R8 interrupt after 3 beats with a new interleaved burst
        issue(col_t'(200), 8, 1'b0, 3, 1'b0, "R8 first");
        repeat (2) @(negedge clk);
        issue(col_t'(77), 4, 1'b1, 4, 1'b0, "R8 second");
        drain(5, "R8 replace");

        // R8 start and stop together: start wins
        issue(col_t'(300), 4, 1'b0, 4, 1'b1, "R8 start+stop");
        drain(5, "R8 start+stop");

        // R9 rejected commands while idle
        bad_cmd(3'd7, 1'b1, "R9 page+il");
        check(col_valid == 1'b0, "R9 idle stays idle", int'(col_valid), 0);
        bad_cmd(3'd5, 1'b0, "R9 code5");
        check(col_valid == 1'b0, "R9 idle stays idle code5", int'(col_valid), 0);
        @(negedge clk);
        check(cfg_reject == 1'b0, "R9 reject one cycle", int'(cfg_reject), 0);

        // R9 rejected command during a burst: burst continues
        issue(col_t'(500), 8, 1'b0, 8, 1'b0, "R9 continue");
        @(negedge clk);
        bad_cmd(3'd4, 1'b1, "R9 in burst");
        drain(7, "R9 continue");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule